// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a host and a 32-bit parallel NOR flash bus made of two 16-bit devices wired side by side. The host hands over one request at a time (identify, erase a sector, or program one word) through a request/acknowledge pair. The block then issues the bus write cycles that request needs, reads back what it must, polls the device status until both devices report ready or a timer runs out, and ends with a one-cycle `done` pulse that carries a 3-bit result code.

Each command byte goes into both 16-bit lanes at once, so both devices act in lockstep. Ready means status bit 7 is set in both lanes. The programming-voltage enable is raised for erase and program work and dropped on every way out of an operation. Before a program cycle, the block reads the target word and refuses the write if the stored bits cannot be turned into the new value.

The bus is single-cycle. A write is one cycle with `fl_we` high. A read is one cycle with `fl_re` high, and `fl_rdata` is sampled at the clock edge that ends that cycle.

Top module: `nor_cmd_seq`

## Requirements
- R1: Every command write places the command byte in bits 7:0 and in bits 23:16, with bits 15:8 and 31:24 zero (for example 0x00AA00AA). Only the program data word is written as given.
- R2: Identify (opcode 0) writes 0xAA at word address 0x5555, 0x55 at 0x2AAA and 0x90 at 0x5555. It then reads address 0 (manufacturer) and address 1 (device), and writes 0xFF at address 0. If both lanes of the manufacturer word equal KNOWN_MFR, the result is 0 and `id_code` holds the device word.
- R3: If the manufacturer word does not match, identify skips the device read, writes 0xFF at address 0, and ends with result 4 and `id_code` zero.
- R4: Erase (opcode 1) writes 0x50, 0x60, 0xD0, 0x50, 0x20 and 0xD0 to the sector address and polls it. On ready it writes 0x50 then 0xFF and ends with result 0.
- R5: Polling continues while status bit 7 (mask 0x00800080) is set in only one lane. Exactly one extra poll read follows the last busy read.
- R6: If the erase timer expires before ready, the block writes 0xB0 and then 0xFF to the sector address and ends with result 1.
- R7: Program (opcode 2) first reads the target word. If (stored AND new) differs from new, it ends with result 2, makes no bus write, and never raises `vpp_en`.
- R8: A program that passes the check writes 0x50, 0x60, 0xD0, 0x40 and then the data word to the target address, polls until ready, writes 0xFF, and ends with result 0.
- R9: If the program timer expires before ready, the block writes 0xFF to the target address and ends with result 1.
- R10: `vpp_en` is high during every bus write of an erase or program and is low whenever no operation is in progress, including after an error.
- R11: `ack` pulses for the one cycle in which an idle block sees `req`. `done` lasts one cycle, and `result` is zero outside it. Opcode 3 is rejected with result 7 and no bus cycle.
- R12: The first poll read happens one cycle after the erase confirm (or program data) write. Time out occurs on the poll read that follows by ERASE_TO (or PROG_TO) cycles, so the next write comes exactly LIMIT+1 cycles after the confirm or data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Host request, held until `ack` |
| req_op | input | 2 | 0 identify, 1 erase, 2 program, 3 invalid |
| req_addr | input | ADDR_W | Sector or word address |
| req_data | input | 32 | Word to program |
| ack | output | 1 | Request accepted (one cycle) |
| done | output | 1 | Operation finished (one cycle) |
| result | output | 3 | 0 ok, 1 timeout, 2 not erased, 4 unknown maker, 7 bad opcode |
| id_code | output | 32 | Device word from the last identify |
| fl_addr | output | ADDR_W | Flash word address |
| fl_wdata | output | 32 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 32 | Flash read data, sampled at the edge ending a read |
| vpp_en | output | 1 | Programming-voltage enable |

## Verification
The bound checker watches, on every cycle, the lane duplication of command writes, the voltage enable around writes and when idle, the single-cycle `ack` and `done`, the absence of voltage on a refused program, and that no timeout fires before its cycle window has elapsed. The exact command orders for each operation, the early exit on an unknown maker, the one-lane-ready case, the timeout branches with their exact spacing, and the result codes depend on a device that answers. Only the bench scenarios, which use a behavioural flash responder, can show them.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  localparam int LANE_W  = 16;
  localparam int BUS_W   = 2 * LANE_W;
  localparam int RDY_BIT = 7;

  localparam logic [1:0] OP_IDENT = 2'd0;
  localparam logic [1:0] OP_ERASE = 2'd1;
  localparam logic [1:0] OP_PROG  = 2'd2;

  localparam logic [2:0] RES_OK    = 3'd0;
  localparam logic [2:0] RES_TMO   = 3'd1;
  localparam logic [2:0] RES_DIRTY = 3'd2;
  localparam logic [2:0] RES_NOID  = 3'd4;
  localparam logic [2:0] RES_BADOP = 3'd7;

  // branch targets inside the step lists below
  localparam logic [3:0] ID_RESET_IDX = 4'd5;
  localparam logic [3:0] ER_SUSP_IDX  = 4'd10;
  localparam logic [3:0] PG_RESET_IDX = 4'd7;
  localparam logic [3:0] PG_END_IDX   = 4'd8;

  typedef enum logic [2:0] {
    SK_WCMD, SK_WDATA, SK_RMFR, SK_RDEV, SK_RCHK, SK_POLL, SK_END
  } step_kind_e;

  typedef enum logic [2:0] {
    AS_SECT, AS_UNLK1, AS_UNLK2, AS_ZERO, AS_ONE
  } addr_sel_e;

  typedef struct packed {
    step_kind_e kind;
    addr_sel_e  asel;
    logic [7:0] cmd;
    logic       tstart;
  } step_t;

  function automatic step_t mk(step_kind_e k, addr_sel_e a, logic [7:0] c, logic t);
    step_t s;
    s.kind = k; s.asel = a; s.cmd = c; s.tstart = t;
    return s;
  endfunction

  function automatic logic [BUS_W-1:0] dup_cmd(logic [7:0] c);
    return {{(LANE_W-8){1'b0}}, c, {(LANE_W-8){1'b0}}, c};
  endfunction

  function automatic logic both_ready(logic [BUS_W-1:0] w);
    return w[RDY_BIT] & w[LANE_W + RDY_BIT];
  endfunction

  function automatic logic fits_erased(logic [BUS_W-1:0] stored, logic [BUS_W-1:0] nw);
    return (stored & nw) == nw;
  endfunction

  function automatic step_t step_of(logic [1:0] op, logic [3:0] idx);
    step_t s;
    s = mk(SK_END, AS_SECT, 8'h00, 1'b0);
    case (op)
      OP_IDENT: case (idx)
        4'd0: s = mk(SK_WCMD, AS_UNLK1, 8'hAA, 1'b0);
        4'd1: s = mk(SK_WCMD, AS_UNLK2, 8'h55, 1'b0);
        4'd2: s = mk(SK_WCMD, AS_UNLK1, 8'h90, 1'b0);
        4'd3: s = mk(SK_RMFR, AS_ZERO,  8'h00, 1'b0);
        4'd4: s = mk(SK_RDEV, AS_ONE,   8'h00, 1'b0);
        4'd5: s = mk(SK_WCMD, AS_ZERO,  8'hFF, 1'b0);
        default: ;
      endcase
      OP_ERASE: case (idx)
        4'd0:  s = mk(SK_WCMD, AS_SECT, 8'h50, 1'b0);
        4'd1:  s = mk(SK_WCMD, AS_SECT, 8'h60, 1'b0);
        4'd2:  s = mk(SK_WCMD, AS_SECT, 8'hD0, 1'b0);
        4'd3:  s = mk(SK_WCMD, AS_SECT, 8'h50, 1'b0);
        4'd4:  s = mk(SK_WCMD, AS_SECT, 8'h20, 1'b0);
        4'd5:  s = mk(SK_WCMD, AS_SECT, 8'hD0, 1'b1);
        4'd6:  s = mk(SK_POLL, AS_SECT, 8'h00, 1'b0);
        4'd7:  s = mk(SK_WCMD, AS_SECT, 8'h50, 1'b0);
        4'd8:  s = mk(SK_WCMD, AS_SECT, 8'hFF, 1'b0);
        4'd10: s = mk(SK_WCMD, AS_SECT, 8'hB0, 1'b0);
        4'd11: s = mk(SK_WCMD, AS_SECT, 8'hFF, 1'b0);
        default: ;
      endcase
      OP_PROG: case (idx)
        4'd0: s = mk(SK_RCHK,  AS_SECT, 8'h00, 1'b0);
        4'd1: s = mk(SK_WCMD,  AS_SECT, 8'h50, 1'b0);
        4'd2: s = mk(SK_WCMD,  AS_SECT, 8'h60, 1'b0);
        4'd3: s = mk(SK_WCMD,  AS_SECT, 8'hD0, 1'b0);
        4'd4: s = mk(SK_WCMD,  AS_SECT, 8'h40, 1'b0);
        4'd5: s = mk(SK_WDATA, AS_SECT, 8'h00, 1'b1);
        4'd6: s = mk(SK_POLL,  AS_SECT, 8'h00, 1'b0);
        4'd7: s = mk(SK_WCMD,  AS_SECT, 8'hFF, 1'b0);
        default: ;
      endcase
      default: ;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/nor_seq_timer.sv
module nor_seq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (start)           cnt_q <= W'(1);
    else if (cnt_q != '1)     cnt_q <= cnt_q + W'(1);
  end

  assign expired = cnt_q >= limit;
endmodule

// File: rtl/nor_seq_status.sv
module nor_seq_status
  import nor_seq_pkg::*;
#(
  parameter logic [LANE_W-1:0] KNOWN_MFR = 16'h0089
) (
  input  logic [BUS_W-1:0] rdata,
  input  logic [BUS_W-1:0] wdata,
  output logic             ready,
  output logic             erased_ok,
  output logic             mfr_ok
);
  assign ready     = both_ready(rdata);
  assign erased_ok = fits_erased(rdata, wdata);
  assign mfr_ok    = rdata == {KNOWN_MFR, KNOWN_MFR};
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          ERASE_TO  = 100000,
  parameter int          PROG_TO   = 2000,
  parameter logic [15:0] KNOWN_MFR = 16'h0089
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_data,
  output logic              ack,
  output logic              done,
  output logic [2:0]        result,
  output logic [31:0]       id_code,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [31:0]       fl_wdata,
  output logic              fl_we,
  output logic              fl_re,
  input  logic [31:0]       fl_rdata,
  output logic              vpp_en
);
  localparam int MAX_TO = (ERASE_TO > PROG_TO) ? ERASE_TO : PROG_TO;
  localparam int TMR_W  = $clog2(MAX_TO + 2);

  logic              busy_q, vpp_q;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       data_q, id_q;
  logic [3:0]        idx_q;
  logic [2:0]        res_q;
  step_t             cur;

  // named internal events
  logic rdy, erased_ok, mfr_ok, tmr_exp;
  logic tmr_start, poll_ok, tmo_hit, data_phase, at_end;
  logic [TMR_W-1:0] tmr_limit;

  assign cur        = step_of(op_q, idx_q);
  assign at_end     = busy_q && cur.kind == SK_END;
  assign data_phase = busy_q && cur.kind == SK_WDATA;
  assign tmr_start  = busy_q && cur.tstart;
  assign poll_ok    = busy_q && cur.kind == SK_POLL && rdy;
  assign tmo_hit    = busy_q && cur.kind == SK_POLL && !rdy && tmr_exp;
  assign tmr_limit  = (op_q == OP_ERASE) ? TMR_W'(ERASE_TO) : TMR_W'(PROG_TO);

  nor_seq_status #(.KNOWN_MFR(KNOWN_MFR)) status_i (
    .rdata(fl_rdata), .wdata(data_q),
    .ready(rdy), .erased_ok(erased_ok), .mfr_ok(mfr_ok)
  );

  nor_seq_timer #(.W(TMR_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .start(tmr_start),
    .limit(tmr_limit), .expired(tmr_exp)
  );

  // bus drive
  always_comb begin
    case (cur.asel)
      AS_UNLK1: fl_addr = ADDR_W'(16'h5555);
      AS_UNLK2: fl_addr = ADDR_W'(16'h2AAA);
      AS_ZERO:  fl_addr = '0;
      AS_ONE:   fl_addr = ADDR_W'(1);
      default:  fl_addr = addr_q;
    endcase
  end

  assign fl_wdata = (cur.kind == SK_WDATA) ? data_q : dup_cmd(cur.cmd);
  assign fl_we    = busy_q && (cur.kind == SK_WCMD || cur.kind == SK_WDATA);
  assign fl_re    = busy_q && (cur.kind == SK_RMFR || cur.kind == SK_RDEV ||
                               cur.kind == SK_RCHK || cur.kind == SK_POLL);
  assign ack      = !busy_q && req;
  assign done     = at_end;
  assign result   = at_end ? res_q : '0;
  assign id_code  = id_q;
  assign vpp_en   = vpp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; vpp_q <= 1'b0; op_q <= OP_IDENT; addr_q <= '0;
      data_q <= '0;   id_q  <= '0;   idx_q <= '0;      res_q  <= RES_OK;
    end else if (ack) begin
      busy_q <= 1'b1;
      op_q   <= req_op;
      addr_q <= req_addr;
      data_q <= req_data;
      idx_q  <= '0;
      res_q  <= (req_op == 2'd3) ? RES_BADOP : RES_OK;
      vpp_q  <= req_op == OP_ERASE;
      if (req_op == OP_IDENT) id_q <= '0;
    end else if (busy_q) begin
      case (cur.kind)
        SK_RMFR: begin
          if (mfr_ok) idx_q <= idx_q + 4'd1;
          else begin idx_q <= ID_RESET_IDX; res_q <= RES_NOID; end
        end
        SK_RDEV: begin
          id_q  <= fl_rdata;
          idx_q <= idx_q + 4'd1;
        end
        SK_RCHK: begin
          if (erased_ok) begin idx_q <= idx_q + 4'd1; vpp_q <= 1'b1; end
          else begin idx_q <= PG_END_IDX; res_q <= RES_DIRTY; end
        end
        SK_POLL: begin
          if (rdy) idx_q <= idx_q + 4'd1;
          else if (tmr_exp) begin
            idx_q <= (op_q == OP_ERASE) ? ER_SUSP_IDX : PG_RESET_IDX;
            res_q <= RES_TMO;
          end
        end
        SK_END: begin
          busy_q <= 1'b0;
          vpp_q  <= 1'b0;
        end
        default: idx_q <= idx_q + 4'd1;
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int ERASE_TO = 100000,
  parameter int PROG_TO  = 2000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic [1:0]  op,
  input logic        ack,
  input logic        done,
  input logic [2:0]  result,
  input logic        fl_we,
  input logic [31:0] fl_wdata,
  input logic        vpp_en,
  input logic        data_phase,
  input logic        tmr_start,
  input logic        tmo_hit
);
  logic [31:0] win_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    win_cnt <= '0;
    else if (tmr_start)            win_cnt <= 32'd1;
    else if (win_cnt != '1)        win_cnt <= win_cnt + 32'd1;
  end

  assert_cmd_dup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we && !data_phase |-> fl_wdata[31:16] == fl_wdata[15:0] && fl_wdata[15:8] == 8'h00);

  assert_dirty_no_vpp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && result == 3'd2 |-> !vpp_en);

  assert_vpp_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we && (op == 2'd1 || op == 2'd2) |-> vpp_en);

  assert_vpp_off_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !vpp_en);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack && busy);

  assert_tmo_window_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |-> win_cnt >= ((op == 2'd1) ? 32'(ERASE_TO) : 32'(PROG_TO)));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.ERASE_TO(ERASE_TO), .PROG_TO(PROG_TO)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .op(op_q), .ack(ack), .done(done),
  .result(result), .fl_we(fl_we), .fl_wdata(fl_wdata), .vpp_en(vpp_en),
  .data_phase(data_phase), .tmr_start(tmr_start), .tmo_hit(tmo_hit)
);

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb_top;
  localparam int AW  = 24;
  localparam int ETO = 40;
  localparam int PTO = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic ack, done, fl_we, fl_re, vpp_en;
  logic [2:0] result;
  logic [31:0] id_code, fl_wdata, fl_rdata;
  logic [AW-1:0] fl_addr;

  always #5 clk = ~clk;

  nor_cmd_seq #(.ADDR_W(AW), .ERASE_TO(ETO), .PROG_TO(PTO), .KNOWN_MFR(16'h0089)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .ack(ack), .done(done), .result(result), .id_code(id_code),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
    .fl_rdata(fl_rdata), .vpp_en(vpp_en)
  );

  // ---------------- behavioural flash responder ----------------
  logic [31:0] mem [16];
  logic [31:0] wa [32], wd [32];
  logic        wv [32];
  int          wc [32];
  int          nwr, nrd, cyc, busy_left;
  logic [1:0]  mode;          // 0 array, 1 id, 2 status
  logic        armed;
  logic [7:0]  last_cmd;
  logic        vpp_seen;
  // driven only by the test tasks
  logic [31:0] mfr_word = 32'h00890089, dev_word = 32'h88028802;
  int          erase_busy = 3, prog_busy = 2;
  logic        one_lane = 1'b0;
  logic        pre_en = 1'b0, clr_log = 1'b0;
  logic [3:0]  pre_a = '0;
  logic [31:0] pre_v = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'hFFFFFFFF;
      nwr <= 0; nrd <= 0; cyc <= 0; busy_left <= 0; mode <= 2'd0;
      armed <= 1'b0; last_cmd <= 8'h00; vpp_seen <= 1'b0;
    end else begin
      cyc <= cyc + 1;
      if (clr_log) begin nwr <= 0; nrd <= 0; vpp_seen <= 1'b0; end
      else begin
        if (vpp_en) vpp_seen <= 1'b1;
        if (fl_re) nrd <= nrd + 1;
        if (fl_we && nwr < 32) begin
          wa[nwr] <= 32'(fl_addr); wd[nwr] <= fl_wdata;
          wv[nwr] <= vpp_en; wc[nwr] <= cyc; nwr <= nwr + 1;
        end
      end
      if (pre_en) mem[pre_a] <= pre_v;
      if (fl_re && mode == 2'd2 && busy_left > 0) busy_left <= busy_left - 1;
      if (fl_we) begin
        if (armed) begin
          mem[fl_addr[3:0]] <= mem[fl_addr[3:0]] & fl_wdata;
          armed <= 1'b0; mode <= 2'd2; busy_left <= prog_busy;
        end else begin
          last_cmd <= fl_wdata[7:0];
          case (fl_wdata[7:0])
            8'hFF: mode <= 2'd0;
            8'h90: mode <= 2'd1;
            8'h40: begin armed <= 1'b1; mode <= 2'd2; end
            8'hD0: begin
              mode <= 2'd2;
              if (last_cmd == 8'h20) begin
                busy_left <= erase_busy;
                mem[fl_addr[3:0]] <= 32'hFFFFFFFF;
              end
            end
            default: mode <= 2'd2;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (mode)
      2'd0:    fl_rdata = mem[fl_addr[3:0]];
      2'd1:    fl_rdata = (fl_addr == '0) ? mfr_word : dev_word;
      default: fl_rdata = (busy_left > 0) ? (one_lane ? 32'h00000080 : 32'h0) : 32'h00800080;
    endcase
  end

  // ---------------- checking helpers ----------------
  int total = 0, bad = 0;
  logic [31:0] ea [16], ed [16];
  int ne;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic exp_clear(); ne = 0; endtask
  task automatic exp_cmd(input logic [31:0] a, input logic [7:0] c);
    ea[ne] = a; ed[ne] = {8'h00, c, 8'h00, c}; ne++;
  endtask
  task automatic exp_word(input logic [31:0] a, input logic [31:0] d);
    ea[ne] = a; ed[ne] = d; ne++;
  endtask

  task automatic check_writes(input string rq, input bit need_vpp);
    chk(nwr == ne, rq, 32'(nwr), 32'(ne));
    for (int i = 0; i < ne && i < nwr; i++) begin
      chk(wa[i] == ea[i], rq, wa[i], ea[i]);
      chk(wd[i] == ed[i], rq, wd[i], ed[i]);
      if (need_vpp) chk(wv[i] == 1'b1, "R10", 32'(wv[i]), 32'd1);
    end
  endtask

  task automatic preset(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk); pre_a = a; pre_v = v; pre_en = 1'b1;
    @(negedge clk); pre_en = 1'b0;
  endtask

  task automatic clear_log();
    @(negedge clk); clr_log = 1'b1;
    @(negedge clk); clr_log = 1'b0;
  endtask

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [31:0] d,
                        output logic [2:0] res);
    int n;
    clear_log();
    req_op = op; req_addr = a; req_data = d; req = 1'b1;
    #1 chk(ack == 1'b1, "R11", 32'(ack), 32'd1);
    @(negedge clk);
    req = 1'b0;
    chk(ack == 1'b0, "R11", 32'(ack), 32'd0);
    n = 0;
    while (!done && n < 5000) begin
      chk(result == 3'd0, "R11", 32'(result), 32'd0);
      @(negedge clk); n++;
    end
    res = result;
    @(negedge clk);
    chk(done == 1'b0, "R11", 32'(done), 32'd0);
    chk(vpp_en == 1'b0, "R10", 32'(vpp_en), 32'd0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(ack == 1'b0 && done == 1'b0, "R11", {30'd0, ack, done}, 32'd0);
    chk(vpp_en == 1'b0, "R10", 32'(vpp_en), 32'd0);
    chk(fl_we == 1'b0 && fl_re == 1'b0, "R11", {30'd0, fl_we, fl_re}, 32'd0);
    chk(id_code == 32'd0, "R2", id_code, 32'd0);
  endtask

  task automatic t_ident_known();
    logic [2:0] r;
    mfr_word = 32'h00890089; dev_word = 32'h88028802;
    run_op(2'd0, '0, '0, r);
    chk(r == 3'd0, "R2", 32'(r), 32'd0);
    chk(id_code == 32'h88028802, "R2", id_code, 32'h88028802);
    chk(nrd == 2, "R2", 32'(nrd), 32'd2);
    exp_clear();
    exp_cmd(32'h5555, 8'hAA); exp_cmd(32'h2AAA, 8'h55);
    exp_cmd(32'h5555, 8'h90); exp_cmd(32'h0, 8'hFF);
    check_writes("R1 R2", 1'b0);
  endtask

  task automatic t_ident_unknown();
    logic [2:0] r;
    mfr_word = 32'h00890012;
    run_op(2'd0, '0, '0, r);
    chk(r == 3'd4, "R3", 32'(r), 32'd4);
    chk(id_code == 32'd0, "R3", id_code, 32'd0);
    chk(nrd == 1, "R3", 32'(nrd), 32'd1);
    exp_clear();
    exp_cmd(32'h5555, 8'hAA); exp_cmd(32'h2AAA, 8'h55);
    exp_cmd(32'h5555, 8'h90); exp_cmd(32'h0, 8'hFF);
    check_writes("R3", 1'b0);
    mfr_word = 32'h00890089;
  endtask

  task automatic t_erase_ok();
    logic [2:0] r;
    erase_busy = 3; one_lane = 1'b0;
    run_op(2'd1, 24'h040002, '0, r);
    chk(r == 3'd0, "R4", 32'(r), 32'd0);
    chk(nrd == 4, "R4", 32'(nrd), 32'd4);
    exp_clear();
    exp_cmd(32'h040002, 8'h50); exp_cmd(32'h040002, 8'h60); exp_cmd(32'h040002, 8'hD0);
    exp_cmd(32'h040002, 8'h50); exp_cmd(32'h040002, 8'h20); exp_cmd(32'h040002, 8'hD0);
    exp_cmd(32'h040002, 8'h50); exp_cmd(32'h040002, 8'hFF);
    check_writes("R4", 1'b1);
  endtask

  task automatic t_erase_one_lane();
    logic [2:0] r;
    erase_busy = 5; one_lane = 1'b1;
    run_op(2'd1, 24'h000006, '0, r);
    chk(r == 3'd0, "R5", 32'(r), 32'd0);
    chk(nrd == 6, "R5", 32'(nrd), 32'd6);
    one_lane = 1'b0;
  endtask

  task automatic t_erase_timeout();
    logic [2:0] r;
    erase_busy = 1000000;
    run_op(2'd1, 24'h000009, '0, r);
    chk(r == 3'd1, "R6", 32'(r), 32'd1);
    exp_clear();
    exp_cmd(32'h9, 8'h50); exp_cmd(32'h9, 8'h60); exp_cmd(32'h9, 8'hD0);
    exp_cmd(32'h9, 8'h50); exp_cmd(32'h9, 8'h20); exp_cmd(32'h9, 8'hD0);
    exp_cmd(32'h9, 8'hB0); exp_cmd(32'h9, 8'hFF);
    check_writes("R6", 1'b1);
    chk(wc[6] - wc[5] == ETO + 1, "R12", 32'(wc[6] - wc[5]), 32'(ETO + 1));
    chk(nrd == ETO, "R12", 32'(nrd), 32'(ETO));
    erase_busy = 3;
  endtask

  task automatic t_prog_dirty();
    logic [2:0] r;
    preset(4'd3, 32'h0000FFFF);
    run_op(2'd2, 24'h000003, 32'h00010001, r);
    chk(r == 3'd2, "R7", 32'(r), 32'd2);
    chk(nwr == 0, "R7", 32'(nwr), 32'd0);
    chk(vpp_seen == 1'b0, "R7", 32'(vpp_seen), 32'd0);
  endtask

  task automatic t_prog_ok();
    logic [2:0] r;
    preset(4'd4, 32'hFFFFFFFF);
    prog_busy = 2;
    run_op(2'd2, 24'h000004, 32'h12345678, r);
    chk(r == 3'd0, "R8", 32'(r), 32'd0);
    exp_clear();
    exp_cmd(32'h4, 8'h50); exp_cmd(32'h4, 8'h60); exp_cmd(32'h4, 8'hD0);
    exp_cmd(32'h4, 8'h40); exp_word(32'h4, 32'h12345678); exp_cmd(32'h4, 8'hFF);
    check_writes("R8", 1'b1);
    chk(mem[4] == 32'h12345678, "R8", mem[4], 32'h12345678);
  endtask

  task automatic t_prog_timeout();
    logic [2:0] r;
    preset(4'd5, 32'hFFFFFFFF);
    prog_busy = 1000000;
    run_op(2'd2, 24'h000005, 32'hA5A5A5A5, r);
    chk(r == 3'd1, "R9", 32'(r), 32'd1);
    exp_clear();
    exp_cmd(32'h5, 8'h50); exp_cmd(32'h5, 8'h60); exp_cmd(32'h5, 8'hD0);
    exp_cmd(32'h5, 8'h40); exp_word(32'h5, 32'hA5A5A5A5); exp_cmd(32'h5, 8'hFF);
    check_writes("R9", 1'b1);
    chk(wc[5] - wc[4] == PTO + 1, "R12", 32'(wc[5] - wc[4]), 32'(PTO + 1));
    prog_busy = 2;
  endtask

  task automatic t_bad_op();
    logic [2:0] r;
    run_op(2'd3, 24'h000001, 32'h0, r);
    chk(r == 3'd7, "R11", 32'(r), 32'd7);
    chk(nwr == 0 && nrd == 0, "R11", 32'(nwr + nrd), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ident_known();
    t_ident_unknown();
    t_erase_ok();
    t_erase_one_lane();
    t_erase_timeout();
    t_prog_dirty();
    t_prog_ok();
    t_prog_timeout();
    t_bad_op();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule